// File: doc/BRIEF.md
# SPI Pixel Upload and Encoded-Stream Readout Peripheral

This block is an SPI peripheral that runs on the system clock. It handles both sides of one compression job. The SPI clock, chip select and MOSI are brought into the system clock domain through a synchronizer chain. The block detects SCK edges there and works in clock polarity 0, phase 1: it samples MOSI on falling SCK edges and moves MISO on rising edges. Bytes travel most significant bit first.

In the upload phase the controller sends a fixed number of pixels. Each pixel is four bytes in red, green, blue, alpha order. The block packs each pixel into one 32-bit word and writes it to consecutive RAM addresses starting at zero. After the last word it raises a ready flag and waits for the encoder's done strobe. The strobe comes with a byte count. The next bytes the controller clocks out begin with the status code 0x80, followed by exactly that many encoded bytes read from a byte-wide RAM port. The block then returns to the upload phase.

Top module: `pix_spi_link`

## Requirements
- R1: After reset, `miso`, `pix_ready` and `wr_en` are all 0.
- R2: MISO changes only after a synchronized rising SCK edge (or a chip-select release). MOSI is captured on falling SCK edges. Bits go most significant first.
- R3: In the upload phase, every four received bytes R, G, B, A form one write of `wr_data = {R,G,B,A}` (R in bits 31:24, A in bits 7:0). The writes go to `wr_addr` 0, 1, 2, … as a one-cycle `wr_en` pulse.
- R4: `pix_ready` rises in the same cycle as the write to address PIXELS-1. It stays high until `enc_done` is sampled high, and falls one cycle after that.
- R5: Bytes received while waiting for the encoder or while streaming cause no RAM write.
- R6: While uploading or waiting, every byte shifted out on MISO is 0x00.
- R7: After `enc_done`, the first byte shifted out is 0x80. It is followed by `enc_len` bytes taken from read addresses 0 to `enc_len`-1 in order.
- R8: After the last streamed byte the block returns to the upload phase. The next upload writes again from address 0, and MISO reads 0x00 during it.
- R9: Releasing chip select in the middle of a byte discards the partial byte and restarts the bit count. A pixel's byte position carries across chip-select frames.
- R10: With `enc_len` = 0, only the 0x80 code is sent before the block returns to the upload phase.
- R11: While chip select is released, `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI clock from the controller (idle low) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |
| wr_en | output | 1 | Pixel word write strobe |
| wr_addr | output | AW | Pixel word address |
| wr_data | output | 32 | Packed pixel {R,G,B,A} |
| pix_ready | output | 1 | All pixels stored; encoder may start |
| enc_done | input | 1 | Encoder finished (sampled while ready) |
| enc_len | input | LEN_W | Number of encoded bytes, captured with `enc_done` |
| rd_addr | output | LEN_W | Encoded-byte read address |
| rd_data | input | 8 | Encoded byte, valid one cycle after `rd_addr` |

## Verification
The assertions assume that each SCK half period lasts well beyond the synchronizer and edge-detect delay. They also assume that chip select changes only while SCK is low, that `enc_done` arrives only between bytes, and that the RAM read port answers one cycle after the address. The stimulus respects all of these. It holds every SCK level for six system clocks and drives every input one time unit after a rising clock edge. It pulses `enc_done` only while the serial line is idle, and it models the encoded-byte RAM as a registered function of the read address.

// File: rtl/pix_spi_pkg.sv
package pix_spi_pkg;

    localparam logic [7:0] STATUS_CODE = 8'h80;

    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_WAIT   = 2'd1,
        PH_STREAM = 2'd2
    } phase_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic [7:0] a;
    } pixel_t;

    function automatic pixel_t make_pixel(input logic [23:0] head, input logic [7:0] tail);
        pixel_t p;
        p.r = head[23:16];
        p.g = head[15:8];
        p.b = head[7:0];
        p.a = tail;
        return p;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mo_p;
    logic              sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            mo_p  <= '0;
            sck_q <= 1'b0;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sck};
            cs_p  <= {cs_p[STAGES-2:0], cs_n};
            mo_p  <= {mo_p[STAGES-2:0], mosi};
            sck_q <= sck_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_q;
    assign sck_fall = ~sck_p[STAGES-1] & sck_q;
    assign sel      = ~cs_p[STAGES-1];
    assign mosi_s   = mo_p[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       sel,
    input  logic       mosi_s,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       tx_start,
    output logic       miso
);
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [6:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_start <= 1'b0;
            miso     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_start <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
                miso    <= 1'b0;
            end else begin
                if (sck_fall) begin
                    rx_sh   <= {rx_sh[5:0], mosi_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        rx_byte  <= {rx_sh, mosi_s};
                        rx_valid <= 1'b1;
                    end
                end
                if (sck_rise) begin
                    if (bit_cnt == 3'd0) begin
                        miso     <= tx_byte[7];
                        tx_sh    <= tx_byte[6:0];
                        tx_start <= 1'b1;
                    end else begin
                        miso  <= tx_sh[6];
                        tx_sh <= {tx_sh[5:0], 1'b0};
                    end
                end
            end
        end
    end

    // R2: MISO only moves after a rising edge or a deselect
    p_miso_moves_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (miso != $past(miso)) |-> ($past(sck_rise) || !$past(sel)));

    // R11: deselect forces MISO low on the next cycle
    p_idle_miso_low_r11: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !miso);
endmodule

// File: rtl/pix_spi_link.sv
module pix_spi_link
    import pix_spi_pkg::*;
#(
    parameter int PIXELS      = 1200,
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW = (PIXELS > 1) ? $clog2(PIXELS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic             pix_ready,
    input  logic             enc_done,
    input  logic [LEN_W-1:0] enc_len,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data
);
    localparam logic [AW-1:0] LAST_PIX = AW'(PIXELS - 1);

    logic sck_rise, sck_fall, sel, mosi_s;
    logic [7:0] rx_byte, tx_byte;
    logic rx_valid, tx_start;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel), .mosi_s(mosi_s)
    );

    spi_byte_shifter u_shift (
        .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel(sel), .mosi_s(mosi_s), .tx_byte(tx_byte), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .tx_start(tx_start), .miso(miso)
    );

    phase_t           phase;
    logic [1:0]       lane;
    logic [23:0]      acc;
    logic [AW-1:0]    pix_idx;
    logic [LEN_W:0]   sidx;
    logic [LEN_W:0]   sidx_m1;
    logic [LEN_W:0]   last_idx;
    logic [LEN_W-1:0] len_q;
    pixel_t           wr_pix;

    assign sidx_m1  = sidx - 1'b1;
    assign last_idx = {1'b0, len_q} + 1'b1;
    assign rd_addr  = (sidx == '0) ? '0 : sidx_m1[LEN_W-1:0];
    assign pix_ready = (phase == PH_WAIT);
    assign wr_data  = wr_pix;

    always_comb begin
        tx_byte = 8'h00;
        if (phase == PH_STREAM) begin
            if (sidx == '0)
                tx_byte = STATUS_CODE;
            else if (sidx <= {1'b0, len_q})
                tx_byte = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_LOAD;
            lane    <= '0;
            acc     <= '0;
            pix_idx <= '0;
            sidx    <= '0;
            len_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_pix  <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (phase)
                PH_LOAD: begin
                    if (rx_valid) begin
                        acc  <= {acc[15:0], rx_byte};
                        lane <= lane + 2'd1;
                        if (lane == 2'd3) begin
                            wr_en   <= 1'b1;
                            wr_addr <= pix_idx;
                            wr_pix  <= make_pixel(acc, rx_byte);
                            if (pix_idx == LAST_PIX) begin
                                pix_idx <= '0;
                                phase   <= PH_WAIT;
                            end else begin
                                pix_idx <= pix_idx + 1'b1;
                            end
                        end
                    end
                end
                PH_WAIT: begin
                    if (enc_done) begin
                        phase <= PH_STREAM;
                        sidx  <= '0;
                        len_q <= enc_len;
                    end
                end
                PH_STREAM: begin
                    if (tx_start)
                        sidx <= sidx + 1'b1;
                    else if (rx_valid && sidx == last_idx) begin
                        sidx  <= '0;
                        phase <= PH_LOAD;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // R4: ready appears together with the final pixel write
    p_ready_with_last_write_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_ready) |-> (wr_en && wr_addr == LAST_PIX));

    // R4: ready only drops after the encoder reported done
    p_ready_drop_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_ready) |-> $past(enc_done));

    // R5: no RAM write once the upload is complete
    p_no_write_while_ready_r5: assert property (@(posedge clk) disable iff (rst)
        $past(pix_ready) |-> !wr_en);

    // R3: write addresses stay inside the pixel array
    p_write_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr <= LAST_PIX));
endmodule

// File: tb/pix_spi_link_test.sv
module pix_spi_link_test;
    localparam int PIXELS = 3;
    localparam int LEN_W  = 8;
    localparam int AW     = 2;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst, sck, cs_n, mosi, enc_done;
    logic [LEN_W-1:0] enc_len;
    logic [7:0] rd_data;
    logic miso, wr_en, pix_ready;
    logic [AW-1:0] wr_addr;
    logic [31:0] wr_data;
    logic [LEN_W-1:0] rd_addr;

    int checks = 0;
    int errors = 0;
    bit run = 0;
    bit finished = 0;
    bit exp_ready = 0;
    int wr_count = 0;
    logic [31:0] last_wr = '0;
    logic [63:0] wq[$];
    int next_addr = 0;

    always #5 clk = ~clk;

    pix_spi_link #(.PIXELS(PIXELS), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pix_ready(pix_ready),
        .enc_done(enc_done), .enc_len(enc_len), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] enc_byte(input int a);
        return 8'(a * 37 + 5);
    endfunction

    always_ff @(posedge clk) rd_data <= enc_byte(int'(rd_addr));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model: compares writes and the ready flag every clock
    always @(negedge clk) begin
        if (run && !rst) begin
            if (wr_en) begin
                checks++;
                if (wq.size() == 0) begin
                    errors++;
                    $display("FAIL R5: actual write %0h@%0d expected none", wr_data, wr_addr);
                end else begin
                    logic [63:0] e;
                    e = wq.pop_front();
                    if ({32'(wr_addr), wr_data} !== e) begin
                        errors++;
                        $display("FAIL R3: actual %0h expected %0h", {32'(wr_addr), wr_data}, e);
                    end
                    if (int'(e[63:32]) == PIXELS - 1) exp_ready = 1;
                end
                wr_count++;
                last_wr = wr_data;
            end
            checks++;
            if (pix_ready !== exp_ready) begin
                errors++;
                $display("FAIL R4: actual pix_ready %0b expected %0b", pix_ready, exp_ready);
            end
            if (exp_ready && enc_done) exp_ready = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b1;
            mosi = tx[b];
            tick(HALF);
            rx[b] = miso;
            sck = 1'b0;
            tick(HALF);
        end
    endtask

    task automatic partial(input int nbits);
        for (int b = 0; b < nbits; b++) begin
            sck = 1'b1;
            mosi = 1'b1;
            tick(HALF);
            sck = 1'b0;
            tick(HALF);
        end
    endtask

    task automatic reframe();
        cs_n = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic send_pixel(input logic [31:0] px, input bit split, input string req);
        logic [7:0] rx;
        wq.push_back({32'(next_addr), px});
        next_addr = (next_addr + 1) % PIXELS;
        for (int k = 3; k >= 0; k--) begin
            xfer(px[k*8 +: 8], rx);
            chk(req, {56'd0, rx}, 64'h00);
            if (split && k == 2) reframe();
        end
    endtask

    task automatic done_pulse(input int len);
        enc_len = LEN_W'(len);
        enc_done = 1'b1;
        tick(1);
        enc_done = 1'b0;
        tick(4);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        rst = 1'b1; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        enc_done = 1'b0; enc_len = '0;
        tick(4);
        // R1: reset state
        chk("R1", {61'd0, miso, pix_ready, wr_en}, 64'd0);
        rst = 1'b0;
        run = 1;
        tick(4);

        // R9: three stray bits, then chip select released
        cs_n = 1'b0;
        tick(2);
        partial(3);
        cs_n = 1'b1;
        tick(4);
        chk("R11", {63'd0, miso}, 64'd0);
        cs_n = 1'b0;
        tick(2);

        send_pixel(32'h11223344, 0, "R6");
        tick(4);
        chk("R9", {32'(wr_count), last_wr}, {32'd1, 32'h11223344});
        send_pixel(32'hA0B1C2D3, 1, "R6"); // R9: pixel split across frames
        send_pixel(32'hFF00FF01, 0, "R6");
        tick(10);
        chk("R4", {63'd0, pix_ready}, 64'd1);
        chk("R3", 64'(wq.size()), 64'd0);

        // R5/R6: bytes while waiting produce zeros and no writes
        xfer(8'h5A, rx);
        chk("R6", {56'd0, rx}, 64'h00);
        tick(4);
        chk("R5", 64'(wr_count), 64'd3);

        done_pulse(5);
        // R2: MISO still low before the first rising edge
        chk("R2", {63'd0, miso}, 64'd0);
        xfer(8'h00, rx);
        chk("R7", {56'd0, rx}, 64'h80);
        for (int i = 0; i < 5; i++) begin
            if (i == 2) begin
                cs_n = 1'b1;
                tick(4);
                chk("R11", {63'd0, miso}, 64'd0);
                cs_n = 1'b0;
                tick(2);
            end
            xfer(8'hC3, rx);
            chk("R7", {56'd0, rx}, {56'd0, enc_byte(i)});
        end
        tick(4);
        chk("R5", 64'(wr_count), 64'd3);

        // R8: new upload restarts at address 0 with zero MISO
        next_addr = 0;
        send_pixel(32'h01020304, 0, "R8");
        send_pixel(32'h05060708, 0, "R8");
        send_pixel(32'h090A0B0C, 0, "R8");
        tick(10);
        chk("R8", {63'd0, pix_ready}, 64'd1);

        // R10: empty encoded stream
        done_pulse(0);
        xfer(8'h00, rx);
        chk("R10", {56'd0, rx}, 64'h80);
        tick(4);
        chk("R10", {63'd0, pix_ready}, 64'd0);
        xfer(8'hAB, rx);
        chk("R8", {56'd0, rx}, 64'h00);
        cs_n = 1'b1;
        tick(10);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule